// File: doc/BRIEF.md
# Reset Cause Capture Register

This block keeps a sticky record of which reset sources have fired, so that boot firmware can read why the chip was last reset. It watches four active-high reset inputs: power-on, the external reset pin, a watchdog timeout (qualified by a watchdog reset-enable level), and a brown-out comparator flag. Each input sets its own status flag. Firmware reads the flags through one 32-bit register and clears any of them by writing a 1 to that bit position.

Power-on is the strongest source. While it is asserted, only the power-on flag is set and the other three are wiped. The three other inputs pass through a two-stage synchronizer and set their flags by level. A source that stays asserted after power-on releases is therefore captured again. One example is a supply that is still below the brown-out level when power-on releases during a slow rise. Only the power-on input initializes the register. The resets it records do not.

Top module: `rstcause_reg`

## Requirements
- R1: While `por_i` is high, the read value is 0x0000_0001: bit 0 (power-on) is set and bits 3:1 are cleared. This takes effect asynchronously, without waiting for a clock edge.
- R2: Bits 31:4 always read 0, and writing ones to them has no effect.
- R3: A write with `wr_en_i` high clears every flag whose `wr_data_i` bit is 1. A write with a 0 in that bit leaves the flag unchanged. The clear is visible after the write's rising edge.
- R4: Bit 0 is never set by the external, watchdog or brown-out inputs. It changes only through power-on or a software clear.
- R5: A high level on `ext_rst_i` sets bit 1. A level sampled high at rising edge k is visible after edge k+2. Only power-on or a software clear brings bit 1 back to 0.
- R6: Bit 2 is set when `wdt_timeout_i` and `wdt_rst_en_i` are both high at the same sampling edge. A timeout with the enable low leaves bit 2 unchanged.
- R7: A brown-out level on `bod_i` that returns low without a power-on sets bit 3, and bit 3 stays set after the dip ends.
- R8: A source input that is still high after `por_i` falls is captured once it has passed the synchronizer. This holds even though power-on has just cleared its flag. A slow rise with `bod_i` high past power-on release ends with the value 0x9.
- R9: When a source sets a flag in the same cycle that software clears it, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous; the only state initializer |
| ext_rst_i | input | 1 | External reset pin level, active high |
| wdt_timeout_i | input | 1 | Watchdog timeout indication |
| wdt_rst_en_i | input | 1 | Watchdog reset enable; a timeout counts only while this is 1 |
| bod_i | input | 1 | Brown-out comparator: supply below the brown-out level |
| wr_en_i | input | 1 | Write strobe for the status register |
| wr_data_i | input | DW | Write data; a 1 clears the matching flag |
| rd_data_o | output | DW | Status register read value |

## Verification
On every cycle, the assertions check the following:
- the power-on value;
- that the power-on flag never rises outside power-on;
- that each synchronized source, including the watchdog only with its enable, sets its flag on the next edge even against a clear;
- that a clear without a competing set takes effect;
- that a watchdog timeout without its enable leaves bit 2 alone.

Other behaviours involve inputs over many cycles, and only the bench's scenarios can show them. These include re-capture of a level still held when power-on releases, the full deep-dip sequence of brown-out, power-on and slow recovery, and the exact two-edge synchronizer latency seen at the read port. Writes of zeros and writes to the reserved bits are also shown by the bench.

// File: rtl/rstcause_reg.sv
module rstcause_reg #(
  parameter int DW   = 32,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          por_i,
  input  logic          ext_rst_i,
  input  logic          wdt_timeout_i,
  input  logic          wdt_rst_en_i,
  input  logic          bod_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int NF = 4;

  logic [SYNC-1:0] ext_sh, wdt_sh, wen_sh, bod_sh;
  logic [NF-1:0]   flags;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      ext_sh <= '0;
      wdt_sh <= '0;
      wen_sh <= '0;
      bod_sh <= '0;
    end else begin
      ext_sh <= {ext_sh[SYNC-2:0], ext_rst_i};
      wdt_sh <= {wdt_sh[SYNC-2:0], wdt_timeout_i};
      wen_sh <= {wen_sh[SYNC-2:0], wdt_rst_en_i};
      bod_sh <= {bod_sh[SYNC-2:0], bod_i};
    end
  end

  wire ext_s = ext_sh[SYNC-1];
  wire wdt_s = wdt_sh[SYNC-1];
  wire wen_s = wen_sh[SYNC-1];
  wire bod_s = bod_sh[SYNC-1];

  wire [NF-1:0] hit = {bod_s, wdt_s & wen_s, ext_s, 1'b0};
  wire [NF-1:0] clr = wr_en_i ? wr_data_i[NF-1:0] : '0;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) flags <= NF'(1);
    else       flags <= (flags & ~clr) | hit;
  end

  assign rd_data_o = {{(DW-NF){1'b0}}, flags};

  logic unused_wr;
  assign unused_wr = ^wr_data_i[DW-1:NF];

  always @(posedge clk)
    if (por_i) p_por_value_r1: assert (rd_data_o == DW'(1));

  p_pwr_bit_no_rise_r4: assert property (@(posedge clk) disable iff (por_i)
    !$rose(rd_data_o[0]));

  p_ext_set_wins_r9: assert property (@(posedge clk) disable iff (por_i)
    ext_s |=> rd_data_o[1]);

  p_wdt_set_r6: assert property (@(posedge clk) disable iff (por_i)
    (wdt_s && wen_s) |=> rd_data_o[2]);

  p_wdt_gated_r6: assert property (@(posedge clk) disable iff (por_i)
    !(wdt_s && wen_s) |=> !$rose(rd_data_o[2]));

  p_bod_set_r7: assert property (@(posedge clk) disable iff (por_i)
    bod_s |=> rd_data_o[3]);

  p_clear_ext_r3: assert property (@(posedge clk) disable iff (por_i)
    (wr_en_i && wr_data_i[1] && !ext_s) |=> !rd_data_o[1]);
endmodule

// File: tb/rstcause_reg_test.sv
module rstcause_reg_test;
  logic clk = 0, por = 0, ext = 0, wdt = 0, wen = 0, bod = 0, wr = 0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  int checks = 0, fails = 0, cycles = 0;
  bit live = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  rstcause_reg uut (.clk(clk), .por_i(por), .ext_rst_i(ext), .wdt_timeout_i(wdt),
    .wdt_rst_en_i(wen), .bod_i(bod), .wr_en_i(wr), .wr_data_i(wd), .rd_data_o(rd));

  bit qe[$], qw[$], qb[$];
  logic [3:0] mdl = 4'h1;

  always @(posedge clk) begin
    cycles++;
    if (por) begin
      mdl = 4'h1;
      qe = {0, 0}; qw = {0, 0}; qb = {0, 0};
    end else begin
      bit ve, vw, vb;
      logic [3:0] c;
      ve = qe.pop_front(); vw = qw.pop_front(); vb = qb.pop_front();
      c = wr ? wd[3:0] : 4'h0;
      mdl = (mdl & ~c) | {vb, vw, ve, 1'b0};
      qe.push_back(ext); qw.push_back(wdt & wen); qb.push_back(bod);
    end
  end

  always @(negedge clk)
    if (live) begin
      checks++;
      if (rd !== {28'h0, mdl}) begin
        fails++;
        $display("FAIL %s model: actual %h expected %h", tag, rd, {28'h0, mdl});
      end
    end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic wreg(input logic [31:0] d);
    wr = 1; wd = d; cyc(1); wr = 0; wd = '0; cyc(1);
  endtask

  task automatic expect_rd(input logic [31:0] e, input string t);
    checks++;
    if (rd !== e) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", t, rd, e);
    end
  endtask

  initial begin
    #1 por = 1; ext = 1;
    cyc(3);
    live = 1;
    tag = "R1"; expect_rd(32'h1, "R1 power-on value");
    por = 0; tag = "R8"; cyc(4);
    expect_rd(32'h3, "R8 ext held past power-on");
    ext = 0; cyc(3);
    tag = "R3"; wreg(32'h2); expect_rd(32'h1, "R3 clear bit1");
    wreg(32'h0); expect_rd(32'h1, "R3 write zero no effect");
    tag = "R2"; wreg(32'hFFFF_FFF0); expect_rd(32'h1, "R2 reserved write");
    tag = "R3"; wreg(32'h1); expect_rd(32'h0, "R3 clear bit0");
    tag = "R5"; ext = 1; cyc(1); ext = 0;
    cyc(1); expect_rd(32'h0, "R5 not yet through sync");
    cyc(1); expect_rd(32'h2, "R5 ext captured");
    tag = "R4"; cyc(2); expect_rd(32'h2, "R4 bit0 untouched");
    wreg(32'h2);
    tag = "R6"; wdt = 1; wen = 0; cyc(3); wdt = 0; cyc(4);
    expect_rd(32'h0, "R6 timeout without enable");
    wen = 1; wdt = 1; cyc(1); wdt = 0; cyc(4);
    expect_rd(32'h4, "R6 timeout with enable");
    wen = 0; wreg(32'h4); expect_rd(32'h0, "R3 clear bit2");
    tag = "R7"; bod = 1; cyc(2); bod = 0; cyc(5);
    expect_rd(32'h8, "R7 brown-out dip recovered");
    wreg(32'h8); expect_rd(32'h0, "R3 clear bit3");
    tag = "R9"; ext = 1; cyc(3);
    wr = 1; wd = 32'h2; cyc(3); wr = 0; wd = '0;
    expect_rd(32'h2, "R9 set beats clear");
    ext = 0; cyc(3); wreg(32'h2); expect_rd(32'h0, "R9 cleared after release");
    tag = "R7"; bod = 1; cyc(3); expect_rd(32'h8, "R7 dip begins");
    tag = "R1"; por = 1; cyc(3); expect_rd(32'h1, "R1 deep dip clears bit3");
    tag = "R8"; por = 0; cyc(3); bod = 0; cyc(4);
    expect_rd(32'h9, "R8 slow rise through brown-out");
    tag = "R3"; wreg(32'hF); expect_rd(32'h0, "R3 clear all");
    cyc(2);
    live = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule